// File: doc/BRIEF.md
# Dual-Lane Pulse Sample Integrator

This block sums the digitized photodetector samples that belong to one scintillation pulse. Every 32-bit input word packs two 16-bit samples. Bits [31:16] hold the upper-group sample and bits [15:0] hold the lower-group sample. Two identical lane units integrate the two halves side by side. A pulse is always 30 words long, so each lane sums 30 samples. Before a sample is added, a programmable baseline is subtracted from it, and a negative result is replaced by zero.

Software drives the block through a small register port. Writing 1 to bit 0 of address 0 arms one pulse. Sample words then arrive on a valid-qualified stream, at most one per clock. Once the 30th word has been taken, both sums are latched into read-only result registers and `done` goes high. The result registers can be read from the register port and also appear directly on output pins. A request to arm while a pulse is still in progress is dropped, and a sticky error flag records it.

The controller has three states:
- `ST_IDLE`: the state after reset; nothing is being summed.
- `ST_INTEG`: words are being summed.
- `ST_DONE`: results are valid.

The controller has four transitions:
- `GO` (`ST_IDLE`→`ST_INTEG`): taken on arm.
- `LAST` (`ST_INTEG`→`ST_DONE`): taken when the 30th word is accepted.
- `REARM` (`ST_DONE`→`ST_INTEG`): taken on arm.
- `HOLD`: stay in the current state otherwise.

Top module: `pulse_pair_integrator`

## Requirements
- R1: After reset the block is idle, `done` is 0, both sums are 0, the baseline reads 0 and the status word (addr 0: bit0 busy, bit1 done, bit2 error) reads 0.
- R2: The upper sum integrates only bits [31:16] of each accepted word, and the lower sum integrates only bits [15:0]. The two lanes are independent.
- R3: Each sample is reduced by the baseline (addr 1, bits [15:0]) before it is added. When the sample is below the baseline, the lane adds zero.
- R4: A write to addr 0 with bit0 set, while not integrating, clears both accumulators and enters `ST_INTEG`. Only cycles with `smp_valid` high count as words, and exactly 30 words form a pulse.
- R5: The sums and `done` update on the clock edge that accepts the 30th word. Before that edge, `done` stays 0. After it, `done` stays 1 until the next arm.
- R6: Words presented while not in `ST_INTEG` change neither the sums nor the result registers.
- R7: An arm request during `ST_INTEG` is ignored: the word count and the partial sums continue unchanged, and status bit2 is set. Bit2 stays set until a write to addr 0 with bit1 set clears it.
- R8: Each lane sum is 21 bits unsigned. Thirty samples of 0xFFFF with baseline 0 give 1966050 with no wrap.
- R9: The result registers (addr 2 upper, addr 3 lower, zero-extended) are read-only, so writes to them leave them unchanged.
- R10: With words on every cycle after the arm write, `done` is high 30 cycles after the arm edge, which is within the 36-cycle pulse budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| smp_valid | input | 1 | Sample word present |
| smp_data | input | 32 | Packed sample pair: upper [31:16], lower [15:0] |
| done | output | 1 | Pulse result valid |
| sum_upper | output | 21 | Latched upper-lane energy sum |
| sum_lower | output | 21 | Latched lower-lane energy sum |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- **Clamp at the baseline.** Samples are placed just below, at and above the baseline. A design that wraps a negative difference would produce huge sums.
- **Full-scale accumulation.** Every sample is at full scale, which catches an accumulator one bit too narrow.
- **Pulse length under stalls.** Gaps are inserted between words, with junk data on the bus during the gaps. A design that counts cycles instead of valid words would finish early and latch junk.
- **Arm request mid-pulse.** An arm arrives in the middle of a pulse. A design that honours it would restart and lose the first words.
- **Inputs that must be ignored.** Stray words after `done` and writes to the result addresses are both applied. A design with broken gating would corrupt results that were already latched.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DONE  = 2'd2
    } ppi_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_BASE  = 2'd1;
    localparam logic [1:0] ADDR_SUMUP = 2'd2;
    localparam logic [1:0] ADDR_SUMLO = 2'd3;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_ERRCLR_BIT = 1;
endpackage

// File: rtl/ppi_lane.sv
module ppi_lane #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                acc_en,
    input  logic                fin,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] baseline,
    output logic [ACC_W-1:0]    result
);
    logic [SAMPLE_W-1:0] diff;
    logic [ACC_W-1:0]    acc;
    logic [ACC_W-1:0]    acc_next;

    always_comb begin
        if (sample > baseline) diff = sample - baseline;
        else                   diff = '0;
        acc_next = acc + ACC_W'(diff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (acc_en) begin
            acc <= acc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (fin) begin
            result <= acc_next;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr) |=> (acc >= $past(acc)));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr && !fin) |=> ($stable(acc) && $stable(result)));

    assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr && (sample <= baseline)) |=> $stable(acc));
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
    import ppi_pkg::*;
#(
    parameter int WORDS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic word_vld,
    output logic clr,
    output logic acc_en,
    output logic fin,
    output logic busy,
    output logic done,
    output logic err_set
);
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

    ppi_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic accept;

    assign accept = (state == ST_INTEG) && word_vld;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_req) state_nx = ST_INTEG;
            ST_INTEG: if (accept && cnt == LAST_IDX) state_nx = ST_DONE;
            ST_DONE:  if (start_req) state_nx = ST_INTEG;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state != ST_INTEG && start_req) cnt <= '0;
            else if (accept) cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        clr     = start_req && (state != ST_INTEG);
        acc_en  = accept;
        fin     = accept && (cnt == LAST_IDX);
        busy    = (state == ST_INTEG);
        done    = (state == ST_DONE);
        err_set = start_req && (state == ST_INTEG);
    end

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST_IDX));

    assert_done_on_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(accept));

    assert_rearm_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && !fin) |=> (busy && $stable(cnt) || busy));

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_req) |=> done);
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 21,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                busy,
    input  logic                done,
    input  logic                err_set,
    input  logic [ACC_W-1:0]    sum_up,
    input  logic [ACC_W-1:0]    sum_lo,
    output logic                start_req,
    output logic [SAMPLE_W-1:0] baseline,
    output logic [DATA_W-1:0]   reg_rdata
);
    logic err;
    logic ctrl_wr;
    logic err_clr;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign start_req = ctrl_wr && reg_wdata[CTRL_START_BIT];
    assign err_clr   = ctrl_wr && reg_wdata[CTRL_ERRCLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baseline <= '0;
            err      <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_BASE) baseline <= reg_wdata[SAMPLE_W-1:0];
            if (err_set)      err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata = DATA_W'({err, done, busy});
            ADDR_BASE:  reg_rdata = DATA_W'(baseline);
            ADDR_SUMUP: reg_rdata = DATA_W'(sum_up);
            ADDR_SUMLO: reg_rdata = DATA_W'(sum_lo);
            default:    reg_rdata = '0;
        endcase
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    assert_err_on_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err);
endmodule

// File: rtl/pulse_pair_integrator.sv
module pulse_pair_integrator
    import ppi_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int WORDS    = 30,
    parameter int ACC_W    = SAMPLE_W + $clog2(WORDS),
    parameter int LANES    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [1:0]                 reg_addr,
    input  logic [LANES*SAMPLE_W-1:0]  reg_wdata,
    output logic [LANES*SAMPLE_W-1:0]  reg_rdata,
    input  logic                       smp_valid,
    input  logic [LANES*SAMPLE_W-1:0]  smp_data,
    output logic                       done,
    output logic [ACC_W-1:0]           sum_upper,
    output logic [ACC_W-1:0]           sum_lower
);
    localparam int DATA_W = LANES * SAMPLE_W;

    logic                clr, acc_en, fin, busy, err_set, start_req;
    logic [SAMPLE_W-1:0] baseline;
    logic [ACC_W-1:0]    lane_res [LANES];

    ppi_ctrl #(.WORDS(WORDS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .word_vld  (smp_valid),
        .clr       (clr),
        .acc_en    (acc_en),
        .fin       (fin),
        .busy      (busy),
        .done      (done),
        .err_set   (err_set)
    );

    // Lane 0 takes the low half (lower group), the highest lane the top half.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ppi_lane #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .acc_en   (acc_en),
            .fin      (fin),
            .sample   (smp_data[g*SAMPLE_W +: SAMPLE_W]),
            .baseline (baseline),
            .result   (lane_res[g])
        );
    end

    assign sum_lower = lane_res[0];
    assign sum_upper = lane_res[LANES-1];

    ppi_regs #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .done      (done),
        .err_set   (err_set),
        .sum_up    (sum_upper),
        .sum_lo    (sum_lower),
        .start_req (start_req),
        .baseline  (baseline),
        .reg_rdata (reg_rdata)
    );

    assert_results_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> ($stable(sum_upper) && $stable(sum_lower)));
endmodule

// File: tb/pulse_pair_integrator_tb_top.sv
module pulse_pair_integrator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        done;
    logic [20:0] sum_upper, sum_lower;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] pw [30];
    logic [15:0] cur_base = '0;

    always #4 clk = ~clk;

    pulse_pair_integrator dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .done(done), .sum_upper(sum_upper), .sum_lower(sum_lower)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [20:0] ref_sum(input bit upper, input logic [15:0] base);
        logic [20:0] s = '0;
        for (int i = 0; i < 30; i++) begin
            logic [15:0] v = upper ? pw[i][31:16] : pw[i][15:0];
            if (v > base) s = s + 21'(v - base);
        end
        return s;
    endfunction

    task automatic send_words(input int lo, input int hi, input int maxgap);
        for (int i = lo; i <= hi; i++) begin
            int g = (maxgap > 0) ? $urandom_range(0, maxgap) : 0;
            for (int k = 0; k < g; k++) begin
                smp_valid = 1'b0; smp_data = $urandom;
                @(negedge clk);
            end
            if (i == 29) chk("R5 done low before last word", 32'(done), 32'd0);
            smp_valid = 1'b1; smp_data = pw[i];
            @(negedge clk);
            smp_valid = 1'b0; smp_data = $urandom;
        end
    endtask

    task automatic check_result(input string tag);
        logic [31:0] r;
        chk({tag, " done"}, 32'(done), 32'd1);
        chk({tag, " upper"}, 32'(sum_upper), 32'(ref_sum(1'b1, cur_base)));
        chk({tag, " lower"}, 32'(sum_lower), 32'(ref_sum(1'b0, cur_base)));
        rd(2'd2, r);
        chk({tag, " R9 read upper"}, r, 32'(ref_sum(1'b1, cur_base)));
        rd(2'd3, r);
        chk({tag, " R9 read lower"}, r, 32'(ref_sum(1'b0, cur_base)));
    endtask

    task automatic set_base(input logic [15:0] b);
        cur_base = b;
        wr(2'd1, 32'(b));
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [20:0] hold_u, hold_l;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 done", 32'(done), 0);
        chk("R1 sum_upper", 32'(sum_upper), 0);
        chk("R1 sum_lower", 32'(sum_lower), 0);
        rd(2'd0, r); chk("R1 status", r, 0);
        rd(2'd1, r); chk("R1 baseline", r, 0);

        // R6 words while idle are ignored
        for (int i = 0; i < 5; i++) begin
            smp_valid = 1'b1; smp_data = 32'hFFFF_FFFF; @(negedge clk);
        end
        smp_valid = 1'b0;
        chk("R6 idle upper", 32'(sum_upper), 0);
        chk("R6 idle lower", 32'(sum_lower), 0);

        // R8 full scale, R10 back-to-back timing
        for (int i = 0; i < 30; i++) pw[i] = 32'hFFFF_FFFF;
        wr(2'd0, 32'h1);
        rd(2'd0, r); chk("R4 busy after arm", r, 32'h1);
        send_words(0, 29, 0);
        chk("R10 done 30 cycles after arm", 32'(done), 1);
        chk("R8 full-scale upper", 32'(sum_upper), 32'd1966050);
        check_result("R8");

        // R2 distinct lanes
        for (int i = 0; i < 30; i++) pw[i] = {16'(i * 1000 + 7), 16'(i * 3)};
        wr(2'd0, 32'h1);
        send_words(0, 29, 2);
        check_result("R2");

        // R3 clamp around the baseline
        set_base(16'h1000);
        for (int i = 0; i < 30; i++)
            pw[i] = {16'h1000 + 16'(i % 3) - 16'd1, 16'h0FFF - 16'(i)};
        wr(2'd0, 32'h1);
        send_words(0, 29, 1);
        check_result("R3");
        chk("R3 lower clamps to zero", 32'(sum_lower), 0);

        // R6 stray words after done
        hold_u = sum_upper; hold_l = sum_lower;
        for (int i = 0; i < 4; i++) begin
            smp_valid = 1'b1; smp_data = $urandom; @(negedge clk);
        end
        smp_valid = 1'b0;
        chk("R6 after-done upper", 32'(sum_upper), 32'(hold_u));
        chk("R6 after-done lower", 32'(sum_lower), 32'(hold_l));

        // R9 writes to result addresses ignored
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h1F_FFFF);
        rd(2'd2, r); chk("R9 upper write ignored", r, 32'(hold_u));
        rd(2'd3, r); chk("R9 lower write ignored", r, 32'(hold_l));

        // R7 arm mid-pulse
        set_base(16'h0100);
        for (int i = 0; i < 30; i++) pw[i] = $urandom;
        wr(2'd0, 32'h1);
        send_words(0, 9, 1);
        wr(2'd0, 32'h1);
        rd(2'd0, r); chk("R7 error set, still busy", r, 32'h5);
        send_words(10, 29, 1);
        check_result("R7");
        rd(2'd0, r); chk("R7 error sticky", r, 32'h6);
        wr(2'd0, 32'h2);
        rd(2'd0, r); chk("R7 error cleared", r, 32'h2);

        // R4/R2/R3 random pulses with stalls
        for (int p = 0; p < 12; p++) begin
            set_base(16'($urandom_range(0, 16'h3FFF)));
            for (int i = 0; i < 30; i++) pw[i] = $urandom;
            wr(2'd0, 32'h1);
            send_words(0, 29, 3);
            check_result("R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule